// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is one clocked register stage for the address and command lines of a memory module. Two static mode inputs set its shape. In the one-copy shape, each of 25 data inputs drives one registered output. In the two-copy shape, only the lower 14 inputs are used, and each of them drives two registered outputs. A second mode input chooses which output pair each input lands on. A chip-select pair decides on each rising clock edge whether the outputs take new values or keep the old ones.

An active-low reset clears every output at once, without waiting for a clock edge. Reset takes priority over the chip-select hold. Reset release passes through a synchronizer and a small arming state machine. The first capture after release therefore happens on a clean edge, and no output can glitch high while the release settles. The arming machine has three states. `ST_CLEAR` is entered asynchronously on reset. It moves to `ST_ARM` once the synchronized release is seen (transition *release*). `ST_ARM` moves to `ST_LIVE` on the next edge (transition *arm*). `ST_LIVE` returns to `ST_CLEAR` only through reset (transition *reset*). Captures are allowed only in `ST_LIVE`.

Top module: `cmdreg_buffer`

## Requirements
- R1: With `width_sel` = 0, a rising edge that captures loads `d_in[i]` into `q_out[i]` for i = 0..24, and `q_out[27:25]` reads 0. The loaded values are visible after that same edge.
- R2: With `width_sel` = 1 and `pin_sel` = 0, a capture loads `d_in[n]` into both `q_out[n]` and `q_out[n+14]` for n = 0..13. In this mode `d_in[24:14]` have no effect on any output.
- R3: With `width_sel` = 1 and `pin_sel` = 1, a capture loads `d_in[n]` into both `q_out[2n]` and `q_out[2n+1]` for n = 0..13.
- R4: When `dcs` and `csr` are both 1 at a rising edge, `q_out` and `dcs_q` keep their previous values. If either of them is 0, the edge captures.
- R5: Driving `rst_n` low clears `q_out` and `dcs_q` to 0 at once, between clock edges, even while the hold condition of R4 is present.
- R6: After `rst_n` rises between edges, the first four rising edges capture nothing and all outputs stay 0. The fifth rising edge is the first capture.
- R7: `dcs_q` is a registered copy of `dcs`. With `csr` held at 0, `dcs_q` follows `dcs` on every edge, one edge late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized |
| width_sel | input | 1 | 0: 25 single-copy lanes; 1: 14 lanes with two copies each |
| pin_sel | input | 1 | Two-copy layout: 0 places copies at n and n+14; 1 places them at 2n and 2n+1 |
| d_in | input | 25 | Command and address data inputs |
| dcs | input | 1 | Chip-select input; also registered to `dcs_q` |
| csr | input | 1 | Second chip-select input; holding the outputs needs both selects high |
| q_out | output | 28 | Registered data outputs |
| dcs_q | output | 1 | Registered copy of `dcs` |

## Verification
The arming machine is the only state beyond the data registers. If it settled in the wrong state, the first capture would land on an edge other than the fifth after release, or the outputs would refuse to move at all. Either fault shows on `q_out` within a handful of cycles of the reset release. A wrong hold decision or a wrong lane mapping shows at the ports on the very edge where it happens. The bench's reference model compares every output on every cycle, so any divergence is reported one edge after its cause.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ARM   = 2'd1,
        ST_LIVE  = 2'd2
    } arm_state_e;

    function automatic int unsigned fanout_width(int unsigned wide_w, int unsigned narrow_w);
        return (2 * narrow_w > wide_w) ? 2 * narrow_w : wide_w;
    endfunction

endpackage

// File: rtl/cmdbuf_arm_fsm.sv
module cmdbuf_arm_fsm
    import cmdbuf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic live
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   released;
    arm_state_e             state_q;
    arm_state_e             state_d;

    // release synchronizer: reset enters asynchronously, leaves on edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
        end
    end

    assign released = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (released) state_d = ST_ARM;
            ST_ARM:   state_d = ST_LIVE;
            ST_LIVE:  state_d = ST_LIVE;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        live = 1'b0;
        unique case (state_q)
            ST_CLEAR: live = 1'b0;
            ST_ARM:   live = 1'b0;
            ST_LIVE:  live = 1'b1;
            default:  live = 1'b0;
        endcase
    end

    // R6: live may only be reached by way of ST_ARM
    assert_arm_before_live_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIVE) |-> ($past(state_q) != ST_CLEAR)
    );

endmodule

// File: rtl/cmdbuf_route.sv
module cmdbuf_route #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int OUT_W    = 28
) (
    input  logic [WIDE_W-1:0] d,
    input  logic              narrow,
    input  logic              interleave,
    output logic [OUT_W-1:0]  mapped
);

    localparam int PAIR_W = 2 * NARROW_W;

    logic [OUT_W-1:0] one_vec;
    logic [OUT_W-1:0] split_vec;
    logic [OUT_W-1:0] pair_vec;

    genvar gi;
    generate
        for (gi = 0; gi < OUT_W; gi++) begin : g_one
            if (gi < WIDE_W) begin : g_used
                assign one_vec[gi] = d[gi];
            end else begin : g_spare
                assign one_vec[gi] = 1'b0;
            end
        end

        for (gi = 0; gi < NARROW_W; gi++) begin : g_two
            assign split_vec[gi]            = d[gi];
            assign split_vec[gi + NARROW_W] = d[gi];
            assign pair_vec[2 * gi]         = d[gi];
            assign pair_vec[2 * gi + 1]     = d[gi];
        end

        for (gi = PAIR_W; gi < OUT_W; gi++) begin : g_two_spare
            assign split_vec[gi] = 1'b0;
            assign pair_vec[gi]  = 1'b0;
        end
    endgenerate

    always_comb begin
        if (!narrow) begin
            mapped = one_vec;
        end else if (!interleave) begin
            mapped = split_vec;
        end else begin
            mapped = pair_vec;
        end
    end

endmodule

// File: rtl/cmdbuf_outreg.sv
module cmdbuf_outreg #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cmdreg_buffer.sv
module cmdreg_buffer
    import cmdbuf_pkg::*;
#(
    parameter int WIDE_W      = 25,
    parameter int NARROW_W    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       width_sel,
    input  logic                                       pin_sel,
    input  logic [WIDE_W-1:0]                          d_in,
    input  logic                                       dcs,
    input  logic                                       csr,
    output logic [fanout_width(WIDE_W, NARROW_W)-1:0]  q_out,
    output logic                                       dcs_q
);

    localparam int OUT_W = fanout_width(WIDE_W, NARROW_W);
    localparam int REG_W = OUT_W + 1;

    logic             live;
    logic             load;
    logic [OUT_W-1:0] mapped;
    logic [REG_W-1:0] reg_q;

    cmdbuf_arm_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live)
    );

    cmdbuf_route #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_route (
        .d          (d_in),
        .narrow     (width_sel),
        .interleave (pin_sel),
        .mapped     (mapped)
    );

    // selects are sampled on the same edge as data; both high means hold
    assign load = live & ~(dcs & csr);

    cmdbuf_outreg #(.W(REG_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     ({dcs, mapped}),
        .q     (reg_q)
    );

    assign q_out = reg_q[OUT_W-1:0];
    assign dcs_q = reg_q[OUT_W];

    assert_one_copy_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load && !width_sel) |=>
            (q_out[WIDE_W-1:0] == $past(d_in)) && (q_out[OUT_W-1:WIDE_W] == '0)
    );

    assert_split_copies_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load && width_sel && !pin_sel) |=>
            (q_out[NARROW_W-1:0] == $past(d_in[NARROW_W-1:0])) &&
            (q_out[2*NARROW_W-1:NARROW_W] == $past(d_in[NARROW_W-1:0]))
    );

    assert_paired_copies_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (load && width_sel && pin_sel) |=>
            (q_out[1:0] == {2{$past(d_in[0])}}) &&
            (q_out[2*NARROW_W-1:2*NARROW_W-2] == {2{$past(d_in[NARROW_W-1])}})
    );

    assert_select_hold_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (dcs && csr) |=> ($stable(q_out) && $stable(dcs_q))
    );

    assert_select_follow_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (live && !csr) |=> (dcs_q == $past(dcs))
    );

endmodule

// File: tb/cmdreg_buffer_test.sv
`timescale 1ns/1ps
module cmdreg_buffer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        width_sel, pin_sel;
    logic [24:0] d_in;
    logic        dcs, csr;
    logic [27:0] q_out;
    logic        dcs_q;

    int total = 0;
    int fails = 0;
    bit cmp_on = 1'b0;

    logic [27:0] m_q;
    logic        m_dq;
    int          m_cnt;

    always #10 clk = ~clk;

    cmdreg_buffer uut (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .pin_sel(pin_sel),
        .d_in(d_in), .dcs(dcs), .csr(csr), .q_out(q_out), .dcs_q(dcs_q)
    );

    function automatic logic [27:0] expect_map(logic [24:0] d, logic w, logic p);
        logic [27:0] r;
        r = '0;
        if (!w) begin
            for (int i = 0; i < 25; i++) r[i] = d[i];
        end else if (!p) begin
            for (int i = 0; i < 14; i++) begin
                r[i] = d[i];
                r[i + 14] = d[i];
            end
        end else begin
            for (int i = 0; i < 14; i++) begin
                r[2 * i] = d[i];
                r[2 * i + 1] = d[i];
            end
        end
        return r;
    endfunction

    // behavioural reference: four dead edges after release, then capture unless both selects high
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
            m_dq <= 1'b0;
            m_cnt <= 0;
        end else if (m_cnt < 4) begin
            m_cnt <= m_cnt + 1;
        end else if (!(dcs && csr)) begin
            m_q <= expect_map(d_in, width_sel, pin_sel);
            m_dq <= dcs;
        end
    end

    task automatic check(input string req, input logic [28:0] act, input logic [28:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            if (m_cnt < 4) check("R6", {dcs_q, q_out}, {m_dq, m_q});
            else if (!width_sel) check("R1", {dcs_q, q_out}, {m_dq, m_q});
            else if (!pin_sel) check("R2", {dcs_q, q_out}, {m_dq, m_q});
            else check("R3", {dcs_q, q_out}, {m_dq, m_q});
        end
    end

    task automatic release_and_watch(input logic [24:0] data);
        @(negedge clk);
        #3 rst_n = 1'b1;
        d_in = data; dcs = 1'b0; csr = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R6", {dcs_q, q_out}, 29'd0);
        end
        @(negedge clk);
        check("R6", {dcs_q, q_out}, {1'b0, expect_map(data, width_sel, pin_sel)});
    endtask

    task automatic run_mode(input logic w, input logic p, input int cycles);
        width_sel = w; pin_sel = p;
        for (int c = 0; c < cycles; c++) begin
            d_in = $urandom;
            dcs = $urandom;
            csr = $urandom;
            @(negedge clk);
        end
    endtask

    initial begin
        #4000000;
        total++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [28:0] snap;
        rst_n = 1'b0; width_sel = 1'b0; pin_sel = 1'b0;
        d_in = '0; dcs = 1'b1; csr = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 reset state", {dcs_q, q_out}, 29'd0);

        // R6 and R1: dead edges, then first capture
        release_and_watch(25'h1FFFFFF);
        cmp_on = 1'b1;

        run_mode(1'b0, 1'b0, 40);
        run_mode(1'b1, 1'b0, 40);
        run_mode(1'b1, 1'b1, 40);
        run_mode(1'b0, 1'b0, 20);

        // R4: both selects high freezes everything
        width_sel = 1'b0; d_in = 25'h0ABCDEF; dcs = 1'b0; csr = 1'b1;
        @(negedge clk);
        snap = {dcs_q, q_out};
        dcs = 1'b1; csr = 1'b1;
        for (int k = 0; k < 5; k++) begin
            d_in = $urandom;
            @(negedge clk);
            check("R4 hold", {dcs_q, q_out}, snap);
        end

        // R7: csr low, dcs_q tracks dcs
        csr = 1'b0;
        for (int k = 0; k < 6; k++) begin
            dcs = k[0];
            @(negedge clk);
            check("R7 dcs follow", {28'd0, dcs_q}, {28'd0, k[0]});
        end

        // R2: upper inputs ignored in split two-copy mode
        width_sel = 1'b1; pin_sel = 1'b0; dcs = 1'b0; csr = 1'b0;
        d_in = 25'h0002A5C;
        @(negedge clk);
        snap = {dcs_q, q_out};
        d_in[24:14] = 11'h7FF;
        @(negedge clk);
        check("R2 upper ignored", {dcs_q, q_out}, snap);
        d_in[24:14] = 11'h2B3;
        @(negedge clk);
        check("R2 upper ignored", {dcs_q, q_out}, snap);

        // R5: reset between edges under hold condition
        width_sel = 1'b0; d_in = 25'h1555555; dcs = 1'b1; csr = 1'b0;
        @(negedge clk);
        csr = 1'b1;
        @(posedge clk);
        #5 rst_n = 1'b0;
        #1 check("R5 async clear", {dcs_q, q_out}, 29'd0);
        @(negedge clk);
        check("R5 held in reset", {dcs_q, q_out}, 29'd0);

        // R6: release with low data keeps outputs low
        width_sel = 1'b1; pin_sel = 1'b1;
        release_and_watch(25'h0);
        release_and_watch_tail();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    task automatic release_and_watch_tail();
        run_mode(1'b1, 1'b1, 20);
        run_mode(1'b0, 1'b0, 10);
    endtask

endmodule